// File: doc/BRIEF.md
# Rotating Framebuffer Scan Address Generator

This block produces the byte address of every 16-bit pixel that a display streaming engine fetches from a framebuffer. A frame consists of a few blanking lines followed by the visible lines, and every line carries the same number of pixels. A downstream consumer pulls one pixel address per accepted beat using a valid/ready handshake. The block offers `valid_o` continuously once it is out of reset and marks the last pixel of each line and of each frame.

Two scan orders are supported. In portrait order the address walks memory linearly through the whole frame, blanking lines included. In landscape order the image is stored column-major. Each output line reads one memory column bottom-up with a stride of one full visible-line count of pixels, so the panel shows the stored picture rotated. In this order every blanking line re-reads the first memory column. The scan order is picked up only at frame boundaries, so a frame is never mixed. The base address is added combinationally, so a change to `base_i` shows on `addr_o` in the same cycle.

Top module: `lcd_scan_addr_gen`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `line_end_o` and `frame_end_o` are 0. From the first rising clock edge after reset is released, `valid_o` stays 1, and the first address is `base_i`.
- R2: A line is PIX_PER_LINE accepted beats and a frame is BLANK_LINES+VIS_LINES lines. `line_end_o` is 1 exactly on the last pixel of a line. `frame_end_o` is 1 exactly on the last pixel of the last line.
- R3: The scan position advances only on a rising edge where `valid_o` and `ready_i` are both 1. Otherwise the position, and with it `addr_o` for an unchanged `base_i`, holds.
- R4: With `mode_i` = 0 (portrait), the address of pixel p of line l (lines counted from 0, blanking first) is base + (l·PIX_PER_LINE + p)·2.
- R5: With `mode_i` = 1 (landscape), pixel p of a blanking line (l < BLANK_LINES) has address base + p·VIS_LINES·2.
- R6: With `mode_i` = 1 (landscape), pixel p of visible line l has address base + (VIS_LINES+BLANK_LINES−1−l)·2 + p·VIS_LINES·2.
- R7: The beat accepted after the last pixel of a frame is followed, with no idle cycle, by line 0, pixel 0 at address `base_i`.
- R8: The scan order in force is the value of `mode_i` captured on the edge that accepts the last pixel of a frame. The first frame after reset is portrait. A change to `mode_i` at any other time has no effect on the current frame.
- R9: `addr_o` follows `base_i` combinationally: it always equals `base_i` plus the offset of the current scan position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_i | input | ADDR_W | Framebuffer byte base address |
| mode_i | input | 1 | Scan order request: 0 portrait, 1 landscape |
| ready_i | input | 1 | Consumer accepts the current address |
| addr_o | output | ADDR_W | Byte address of the current pixel |
| valid_o | output | 1 | Address is valid |
| line_end_o | output | 1 | Current pixel is the last of its line |
| frame_end_o | output | 1 | Current pixel is the last of the frame |

## Verification
On every cycle the assertions check the following: the counters stay within range, the position holds when a beat is stalled, a frame-end marker always coincides with a line-end marker, the offset returns to zero after a frame wraps, and the latched scan order changes only on a frame-end acceptance. The address arithmetic in both orders can only be shown by the bench's scenarios. So can the reversed column order of landscape lines, the blanking re-reads, and the capture timing of `mode_i` against a randomly toggling request. The bench compares every cycle against closed-form address formulas while ready, mode and base change at random.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic {
    SCAN_PORTRAIT  = 1'b0,
    SCAN_LANDSCAPE = 1'b1
  } scan_mode_e;
endpackage

// File: rtl/lcd_scan_counter.sv
module lcd_scan_counter #(
  parameter int PIX_PER_LINE = 240,
  parameter int NUM_LINES    = 329,
  localparam int PIX_W  = $clog2(PIX_PER_LINE),
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              acc_o,
  output logic [LINE_W-1:0] line_o,
  output logic              line_end_o,
  output logic              frame_end_o
);
  localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(PIX_PER_LINE - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(NUM_LINES - 1);

  logic [PIX_W-1:0]  pix_q;
  logic [LINE_W-1:0] line_q;
  logic              valid_q;

  assign valid_o     = valid_q;
  assign acc_o       = valid_q & ready_i;
  assign line_o      = line_q;
  assign line_end_o  = valid_q && (pix_q == PIX_LAST);
  assign frame_end_o = line_end_o && (line_q == LINE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pix_q   <= '0;
      line_q  <= '0;
    end else begin
      valid_q <= 1'b1;
      if (acc_o) begin
        if (pix_q == PIX_LAST) begin
          pix_q  <= '0;
          line_q <= (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
        end else begin
          pix_q <= pix_q + 1'b1;
        end
      end
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_q <= PIX_LAST) && (line_q <= LINE_LAST));

  a_r2_frame_has_line_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> line_end_o);

  a_r3_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> ($stable(pix_q) && $stable(line_q)));
endmodule

// File: rtl/lcd_scan_offset.sv
module lcd_scan_offset
  import lcd_scan_pkg::*;
#(
  parameter int PIX_PER_LINE = 240,
  parameter int VIS_LINES    = 320,
  parameter int BLANK_LINES  = 9,
  parameter int BYTES_PIX    = 2,
  localparam int NUM_LINES = VIS_LINES + BLANK_LINES,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int OFF_W     = $clog2(NUM_LINES * PIX_PER_LINE * BYTES_PIX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              acc_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              line_end_i,
  input  logic              frame_end_i,
  output logic [OFF_W-1:0]  off_o
);
  localparam logic [OFF_W-1:0] STEP_PORT  = OFF_W'(BYTES_PIX);
  localparam logic [OFF_W-1:0] STEP_LAND  = OFF_W'(VIS_LINES * BYTES_PIX);
  localparam logic [OFF_W-1:0] LINE_PORT  = OFF_W'(PIX_PER_LINE * BYTES_PIX);
  localparam logic [OFF_W-1:0] FIRST_VIS  = OFF_W'((VIS_LINES - 1) * BYTES_PIX);

  scan_mode_e       mode_q;
  logic [OFF_W-1:0] line_off_q, pix_off_q, line_off_d;
  int               next_line;

  assign off_o     = line_off_q + pix_off_q;
  assign next_line = int'(line_i) + 1;

  // start offset of the following line
  always_comb begin
    if (mode_q == SCAN_PORTRAIT)        line_off_d = line_off_q + LINE_PORT;
    else if (next_line < BLANK_LINES)   line_off_d = '0;
    else if (next_line == BLANK_LINES)  line_off_d = FIRST_VIS;
    else                                line_off_d = line_off_q - STEP_PORT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= SCAN_PORTRAIT;
      line_off_q <= '0;
      pix_off_q  <= '0;
    end else if (acc_i) begin
      if (frame_end_i) begin
        mode_q     <= scan_mode_e'(mode_i);
        line_off_q <= '0;
        pix_off_q  <= '0;
      end else if (line_end_i) begin
        line_off_q <= line_off_d;
        pix_off_q  <= '0;
      end else begin
        pix_off_q <= pix_off_q + ((mode_q == SCAN_PORTRAIT) ? STEP_PORT : STEP_LAND);
      end
    end
  end

  a_r7_wrap_to_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && frame_end_i) |=> (off_o == '0));

  a_r8_mode_frame_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_i && frame_end_i) |=> $stable(mode_q));

  a_r3_offset_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(off_o));
endmodule

// File: rtl/lcd_scan_addr_gen.sv
module lcd_scan_addr_gen #(
  parameter int PIX_PER_LINE = 240,
  parameter int VIS_LINES    = 320,
  parameter int BLANK_LINES  = 9,
  parameter int ADDR_W       = 32,
  localparam int BYTES_PIX = 2,
  localparam int NUM_LINES = VIS_LINES + BLANK_LINES,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int OFF_W     = $clog2(NUM_LINES * PIX_PER_LINE * BYTES_PIX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              mode_i,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              line_end_o,
  output logic              frame_end_o
);
  logic              acc;
  logic [LINE_W-1:0] line;
  logic [OFF_W-1:0]  off;

  lcd_scan_counter #(
    .PIX_PER_LINE(PIX_PER_LINE),
    .NUM_LINES   (NUM_LINES)
  ) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ready_i    (ready_i),
    .valid_o    (valid_o),
    .acc_o      (acc),
    .line_o     (line),
    .line_end_o (line_end_o),
    .frame_end_o(frame_end_o)
  );

  lcd_scan_offset #(
    .PIX_PER_LINE(PIX_PER_LINE),
    .VIS_LINES   (VIS_LINES),
    .BLANK_LINES (BLANK_LINES),
    .BYTES_PIX   (BYTES_PIX)
  ) u_offset (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .acc_i      (acc),
    .line_i     (line),
    .line_end_i (line_end_o),
    .frame_end_i(frame_end_o),
    .off_o      (off)
  );

  assign addr_o = base_i + ADDR_W'(off);

  a_r1_valid_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  a_r3_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> ($stable(base_i) -> $stable(addr_o)));
endmodule

// File: tb/lcd_scan_addr_gen_tb.sv
module lcd_scan_addr_gen_tb;
  localparam int PIX   = 4;
  localparam int VIS   = 5;
  localparam int BLANK = 2;
  localparam int LINES = VIS + BLANK;
  localparam int AW    = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] base_i = 32'h0000_1000;
  logic          mode_i = 1'b0;
  logic          ready_i = 1'b0;
  logic [AW-1:0] addr_o;
  logic          valid_o, line_end_o, frame_end_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk_i = ~clk_i;

  lcd_scan_addr_gen #(
    .PIX_PER_LINE(PIX), .VIS_LINES(VIS), .BLANK_LINES(BLANK), .ADDR_W(AW)
  ) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_i(base_i), .mode_i(mode_i),
    .ready_i(ready_i), .addr_o(addr_o), .valid_o(valid_o),
    .line_end_o(line_end_o), .frame_end_o(frame_end_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input bit land, input int ln, input int px,
                                             input logic [AW-1:0] b);
    if (!land)            return b + AW'((ln * PIX + px) * 2);
    else if (ln < BLANK)  return b + AW'(px * VIS * 2);
    else                  return b + AW'((VIS + BLANK - 1 - ln) * 2 + px * VIS * 2);
  endfunction

  initial begin
    int ln = 0, px = 0, frame = 0;
    bit land = 0, wrapped = 0, stalled = 0, base_chg = 0;
    logic [AW-1:0] exp, prev_addr;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R1 valid in reset", AW'(valid_o), 0);
    chk(line_end_o == 1'b0 && frame_end_o == 1'b0, "R1 markers in reset",
        AW'({line_end_o, frame_end_o}), 0);
    rst_ni = 1'b1;
    prev_addr = '0;
    for (int cyc = 0; cyc < 3000 && frame < 14; cyc++) begin
      @(negedge clk_i);
      exp = exp_addr(land, ln, px, base_i);
      if (cyc == 0) begin
        chk(valid_o == 1'b1, "R1 valid after reset", AW'(valid_o), 1);
        chk(addr_o == base_i, "R1 first address", addr_o, base_i);
      end
      chk(valid_o == 1'b1, "R1 valid held", AW'(valid_o), 1);
      if (frame == 0)    chk(addr_o == exp, "R8 first frame portrait", addr_o, exp);
      if (wrapped)       chk(addr_o == base_i, "R7 wrap to base", addr_o, base_i);
      if (base_chg)      chk(addr_o == exp, "R9 base follows", addr_o, exp);
      if (stalled && !base_chg)
        chk(addr_o == prev_addr, "R3 hold on stall", addr_o, prev_addr);
      if (!land)            chk(addr_o == exp, "R4 portrait address", addr_o, exp);
      else if (ln < BLANK)  chk(addr_o == exp, "R5 landscape blanking", addr_o, exp);
      else                  chk(addr_o == exp, "R6 landscape visible", addr_o, exp);
      chk(line_end_o == (px == PIX - 1), "R2 line end", AW'(line_end_o), AW'(px == PIX - 1));
      chk(frame_end_o == (px == PIX - 1 && ln == LINES - 1), "R2 frame end",
          AW'(frame_end_o), AW'(px == PIX - 1 && ln == LINES - 1));
      prev_addr = addr_o;
      wrapped   = 0;
      ready_i   = ($urandom % 4) != 0;
      mode_i    = ($urandom % 2) == 1;  // R8: toggles freely inside a frame
      base_chg  = (cyc % 97) == 50;
      if (base_chg) base_i = 32'h0001_0000 + AW'(($urandom % 256) * 2);
      stalled = !ready_i;
      if (ready_i) begin
        if (px == PIX - 1) begin
          px = 0;
          if (ln == LINES - 1) begin
            ln = 0;
            land = mode_i;
            wrapped = 1;
            frame++;
          end else ln++;
        end else px++;
      end
    end
    if (frame < 14) chk(0, "R2 frame progress", AW'(frame), 14);
    done = 1;
  end

  initial begin
    int wd = 0;
    while (!done && wd < 200000) begin
      @(posedge clk_i);
      wd++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected completion", wd);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule